// File: doc/BRIEF.md
# Lockstep Pipeline Flow Controller

This block governs the flow of data through a fixed-depth chain of pipeline registers that all stall together. It keeps one validity flag per stage in a shift chain that moves in lockstep with the data registers, and it produces a single advance enable shared by every stage. Upstream and downstream each see a valid/ready handshake, so the pipeline can be placed between any two producer and consumer blocks that follow those rules.

A combinational ready term is formed from the occupancy of the last stage and the downstream ready. That term is the upstream ready, and when it is combined with the active-high chip enable it becomes the advance enable. When the pipeline advances, the upstream valid flag and data word enter the first stage and every stage moves one step toward the output. A bubble in the last stage lets the pipeline keep filling while the output is stalled. The data chain is not reset. Only the validity flags are cleared, and the polarity of the reset input is a parameter.

Top module: `lockstep_pipe`

## Requirements
- R1: With the default depth parameter of 3, a word accepted on one rising edge has out_valid high with that word on out_data after exactly 3 rising edges on which adv_en is high, and not earlier.
- R2: While the reset input is at its active level (high when RST_HIGH is 1, low when RST_HIGH is 0), every validity flag is cleared on the next rising edge, so out_valid reads 0 after that edge.
- R3: in_ready is high exactly when out_ready is high or out_valid is low. It does not depend on ce.
- R4: adv_en is high exactly when in_ready and ce are both high.
- R5: On a rising edge with adv_en high, in_valid and in_data load into the first stage and each stage takes the contents of the stage before it.
- R6: On a rising edge with ce low, neither the validity flags nor the data registers change, whatever the handshake inputs are.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data keeps its value on the next edge, and in_ready is low.
- R8: A word is accepted when in_valid, in_ready and ce are all high, and it is delivered when out_valid, out_ready and ce are all high. Every accepted word is delivered exactly once, in order of acceptance, under arbitrary in_valid, out_ready and ce patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Reset; its active level is set by RST_HIGH |
| ce | input | 1 | Active-high chip enable |
| in_valid | input | 1 | Upstream word is valid |
| in_data | input | WIDTH | Upstream data word |
| in_ready | output | 1 | Pipeline can take a word |
| out_valid | output | 1 | Last stage holds a valid word |
| out_data | output | WIDTH | Word in the last stage |
| out_ready | input | 1 | Downstream can take a word |
| adv_en | output | 1 | Shared advance enable for all stages |

## Verification
The hardest case to reach is a pipeline that is full while its output is stalled, and that then also sees the chip enable drop. Only in that state can a word be overwritten or delivered twice. The stimulus gets there by holding out_ready low while three words are fed back to back. It then lowers ce with out_ready high and checks that the head word does not move. After that it drains the pipeline, and a long run of random valid, ready and enable patterns follows, with each delivered word compared against a queue of accepted words.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;

  // Map the raw reset pin to an active flag for the chosen polarity.
  function automatic logic reset_on(input logic rst_pin, input bit active_high);
    return active_high ? rst_pin : ~rst_pin;
  endfunction

endpackage

// File: rtl/pipe_valid_chain.sv
module pipe_valid_chain #(
  parameter int STAGES   = 3,
  parameter bit RST_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic in_valid,
  input  logic out_ready,
  output logic ready,
  output logic adv_en,
  output logic out_valid
);

  localparam int LAST = STAGES - 1;

  logic              rst_act;
  logic [LAST:0]     vld_q;
  logic [LAST:0]     vld_next;

  assign rst_act = lockstep_pkg::reset_on(rst, RST_HIGH);

  // A bubble in the last stage, or a consumer that is ready, frees one slot.
  assign ready     = out_ready | ~vld_q[LAST];
  assign adv_en    = ready & ce;
  assign out_valid = vld_q[LAST];

  generate
    if (STAGES == 1) begin : g_single
      assign vld_next = in_valid;
    end else begin : g_multi
      assign vld_next = {vld_q[LAST-1:0], in_valid};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst_act) begin
      vld_q <= '0;
    end else if (adv_en) begin
      vld_q <= vld_next;
    end
  end

  // R2: reset clears every flag
  p_reset_clears_r2: assert property (@(posedge clk)
    rst_act |=> vld_q == '0);

  // R5: first stage takes the upstream valid on an advance
  p_stage0_load_r5: assert property (@(posedge clk) disable iff (rst_act)
    adv_en |=> vld_q[0] == $past(in_valid));

  // R6: chip enable low freezes the flags
  p_freeze_r6: assert property (@(posedge clk) disable iff (rst_act)
    !ce |=> $stable(vld_q));

  generate
    if (STAGES > 1) begin : g_shift_chk
      // R5: every later stage takes the one before it
      p_shift_r5: assert property (@(posedge clk) disable iff (rst_act)
        adv_en |=> vld_q[LAST:1] == $past(vld_q[LAST-1:0]));
    end
  endgenerate

endmodule

// File: rtl/pipe_data_chain.sv
module pipe_data_chain #(
  parameter int STAGES = 3,
  parameter int WIDTH  = 32
) (
  input  logic             clk,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  // Plain enabled registers with no reset, so they map onto fabric flops.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (en) stage_q[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (en) stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[LAST];

endmodule

// File: rtl/lockstep_pipe.sv
module lockstep_pipe #(
  parameter int STAGES   = 3,
  parameter int WIDTH    = 32,
  parameter bit RST_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  input  logic             out_ready,
  output logic             adv_en
);

  logic rst_act;
  assign rst_act = lockstep_pkg::reset_on(rst, RST_HIGH);

  pipe_valid_chain #(
    .STAGES   (STAGES),
    .RST_HIGH (RST_HIGH)
  ) u_valid (
    .clk       (clk),
    .rst       (rst),
    .ce        (ce),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .ready     (in_ready),
    .adv_en    (adv_en),
    .out_valid (out_valid)
  );

  pipe_data_chain #(
    .STAGES (STAGES),
    .WIDTH  (WIDTH)
  ) u_data (
    .clk  (clk),
    .en   (adv_en),
    .din  (in_data),
    .dout (out_data)
  );

  // R7: a stalled head word neither vanishes nor changes
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst_act)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6: with ce low the delivered word stays put
  p_data_freeze_r6: assert property (@(posedge clk) disable iff (rst_act)
    (out_valid && !ce) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/lockstep_pipe_tb.sv
module lockstep_pipe_tb;

  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid, adv_en;
  logic [W-1:0] out_data;

  logic rst_n_b;
  logic nb_in_ready, nb_out_valid, nb_adv;
  logic [7:0] nb_out_data;

  int checks = 0, errors = 0;
  logic [W-1:0] exp_q [$];
  bit done = 0;

  always #4 clk = ~clk;

  lockstep_pipe #(.STAGES(3), .WIDTH(W), .RST_HIGH(1'b1)) u_dut (
    .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .adv_en(adv_en));

  // Second copy with an active-low reset, always fed and never drained.
  assign rst_n_b = ~rst;
  lockstep_pipe #(.STAGES(3), .WIDTH(8), .RST_HIGH(1'b0)) u_dut_n (
    .clk(clk), .rst(rst_n_b), .ce(1'b1), .in_valid(1'b1), .in_data(8'h5a),
    .in_ready(nb_in_ready), .out_valid(nb_out_valid), .out_data(nb_out_data),
    .out_ready(1'b0), .adv_en(nb_adv));

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: set inputs after a falling edge, record accepted words.
  task automatic cyc(input logic iv, input logic [W-1:0] d, input logic ordy, input logic c);
    @(negedge clk);
    in_valid = iv; in_data = d; out_ready = ordy; ce = c;
    #1;
    if (!rst && in_valid && in_ready && ce) exp_q.push_back(d);
  endtask

  // Monitor: compare delivered words with the queue.
  always @(negedge clk) begin
    #2;
    if (!rst && out_valid && out_ready && ce) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 spurious output", out_data, '0);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(out_data === e, "R8 order", out_data, e);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc(0, '0, 0, 1);
    check(out_valid === 1'b0, "R2 reset clears", out_valid, 0);
    check(nb_out_valid === 1'b0, "R2 low-polarity reset", nb_out_valid, 0);
    @(negedge clk); rst = 1'b0;
    #1;
    check(in_ready === 1'b1, "R3 empty ready", in_ready, 1);
    check(adv_en === 1'b1, "R4 enable with ce", adv_en, 1);

    // R1 / R5 latency through three stages
    cyc(1, 32'hA0A0_0001, 1, 1);
    cyc(0, '0, 1, 1);
    check(out_valid === 1'b0, "R1 not early 1", out_valid, 0);
    cyc(0, '0, 1, 1);
    check(out_valid === 1'b0, "R1 not early 2", out_valid, 0);
    cyc(0, '0, 1, 1);
    check(out_valid === 1'b1 && out_data === 32'hA0A0_0001, "R1 R5 arrival", out_data, 32'hA0A0_0001);
    check(nb_out_valid === 1'b1, "R2 low-polarity release", nb_out_valid, 1);
    cyc(0, '0, 1, 1);

    // ce low ignores a valid input: R4, R6
    cyc(1, 32'hDEAD_0000, 1, 0);
    check(adv_en === 1'b0, "R4 ce low", adv_en, 0);
    check(in_ready === 1'b1, "R3 ready ignores ce", in_ready, 1);
    repeat (4) cyc(0, '0, 1, 1);
    check(out_valid === 1'b0, "R6 ce-low word not taken", out_valid, 0);

    // Fill with output stalled: R7, R3
    cyc(1, 32'h0000_00B1, 0, 1);
    cyc(1, 32'h0000_00C2, 0, 1);
    cyc(1, 32'h0000_00D3, 0, 1);
    cyc(1, 32'h0000_00E4, 0, 1);
    check(in_ready === 1'b0, "R3 R7 full stall ready low", in_ready, 0);
    check(out_valid === 1'b1 && out_data === 32'h0000_00B1, "R7 head word", out_data, 32'h0000_00B1);
    repeat (3) cyc(1, 32'h0000_00E4, 0, 1);
    check(out_valid === 1'b1 && out_data === 32'h0000_00B1, "R7 held", out_data, 32'h0000_00B1);

    // ce low with downstream ready: nothing moves (R6)
    repeat (3) cyc(1, 32'h0000_00F5, 1, 0);
    check(adv_en === 1'b0, "R6 no advance", adv_en, 0);
    check(out_valid === 1'b1 && out_data === 32'h0000_00B1, "R6 frozen head", out_data, 32'h0000_00B1);

    // Drain
    repeat (6) cyc(0, '0, 1, 1);
    check(exp_q.size() == 0, "R8 drained", exp_q.size(), 0);
    check(out_valid === 1'b0, "R8 empty after drain", out_valid, 0);

    // Random traffic: R8
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] d;
      d = $urandom;
      cyc(($urandom % 3) != 0, d, ($urandom % 4) != 0, ($urandom % 5) != 0);
    end
    repeat (8) cyc(0, '0, 1, 1);
    check(exp_q.size() == 0, "R8 all delivered", exp_q.size(), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule